// File: doc/BRIEF.md
# Debug Scan Register Chain with Host/Core Mailbox

This block is the data register that sits behind a debug TAP on the target side. An external TAP controller supplies the capture, shift and update strobes together with TDI. The block returns TDO. Through this register, a JTAG host can read and write a small file of debug registers. It can also exchange 32-bit words with the processor core over a two-way mailbox. The core side of the mailbox is a plain valid/ready word interface in the same clock domain.

Every scan carries 38 bits, least significant bit first. Bits 31:0 are the data word, bits 36:32 the register address, and bit 37 the direction: 1 writes, 0 reads. A write takes effect at the update strobe. A read takes two scans. The update of the first scan latches the address, and the capture of the next scan loads that register into the data field. Capturing the mailbox data register takes the word out of the core-to-host slot. For this reason, a host normally ends a run of reads with a read scan that addresses the side-effect-free mailbox status register.

Top module: `dbg_scan_chain`

## Requirements
- R1: The chain is 38 bits, shifts from TDI toward TDO one bit per shift cycle, and presents bit 0 of the chain on `tdo`, which changes only on the falling clock edge and is 0 after reset.
- R2: An update with bit 37 = 1 and address 0 writes the low 6 data bits into debug control (bit 4 of which drives `monitor_en`), and address 2 writes the low 8 bits into vector catch.
- R3: An update with bit 37 = 0 latches the read address. Each following capture loads that register zero-extended into bits 31:0, with bits 37:32 zero. Write scans leave the read address unchanged.
- R4: Reset clears debug control, vector catch, both mailbox flags and the read address (address 0).
- R5: Address 4 (mailbox status) reads the parameter `VERSION` in bits 31:28, the host-to-core flag in bit 0 and the core-to-host flag in bit 1, and zero elsewhere. Reading it changes nothing.
- R6: A write to address 5 while the host-to-core flag is 0 stores the word on `core_rx_data` and sets the flag (`core_rx_valid`). While the flag is 1, such a write is dropped and the held word stays.
- R7: `core_rx_ack` while `core_rx_valid` is 1 clears the host-to-core flag.
- R8: `core_tx_ready` is the inverse of the core-to-host flag. `core_tx_valid` with `core_tx_ready` stores `core_tx_data` and sets the flag; a send while not ready is dropped.
- R9: A capture whose read address is 5 returns the stored core-to-host word and clears the core-to-host flag, so two consecutive captures at address 5 consume twice.
- R10: Addresses other than 0, 1, 2, 4 and 5 read as zero. Writes to them, to address 1 and to address 4 change no state.
- R11: Address 1 (debug status) returns the 5-bit `dbg_status` input as sampled at the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock (TCK) |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_dr | input | 1 | Capture strobe from TAP |
| shift_dr | input | 1 | Shift strobe from TAP |
| update_dr | input | 1 | Update strobe from TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| dbg_status | input | 5 | Live debug status bits from the core |
| dbg_ctrl | output | 6 | Debug control register |
| monitor_en | output | 1 | Monitor-mode enable (debug control bit 4) |
| vec_catch | output | 8 | Vector catch register |
| core_tx_valid | input | 1 | Core offers a word to the host |
| core_tx_data | input | 32 | Word from the core |
| core_tx_ready | output | 1 | Core-to-host slot is empty |
| core_rx_valid | output | 1 | Host-to-core word waiting |
| core_rx_data | output | 32 | Word from the host |
| core_rx_ack | input | 1 | Core has taken the host word |

## Verification
The bench attacks the one-scan read delay and checks that a write scan placed between reads does not move the read address. A design that latched the address on every update would return the wrong register. It repeats captures at the mailbox data address and expects each one to consume a word. A design that consumed only on the address update would hand the same word out twice, or lose the one sent in between. It also sends into a full slot from both sides, expecting the held word to survive, and writes oversized values to narrow and read-only registers, expecting truncation and no state change.

// File: rtl/dbg_chain_pkg.sv
// Shared widths, addresses and scan-word layout for the debug scan chain.
// Assumes a single clock domain (TCK) for both host and core sides.
package dbg_chain_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int SCAN_W   = DATA_W + ADDR_W + 1;
    localparam int CTRL_W   = 6;
    localparam int STAT_W   = 5;
    localparam int VEC_W    = 8;
    localparam int VER_W    = 4;
    localparam int MON_BIT  = 4;
    localparam int RFLAG_BIT = 0;
    localparam int WFLAG_BIT = 1;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 5'd1;
    localparam logic [ADDR_W-1:0] A_VEC   = 5'd2;
    localparam logic [ADDR_W-1:0] A_MBSTS = 5'd4;
    localparam logic [ADDR_W-1:0] A_MBDAT = 5'd5;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } scan_word_t;
endpackage

// File: rtl/dbg_scan_shift.sv
// Serial scan register: parallel load on capture, LSB-first shift, TDO
// retimed on the falling edge. Assumes the strobes are mutually exclusive.
module dbg_scan_shift #(
    parameter int W = 38
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_word,
    output logic [W-1:0] sr_q,
    output logic         tdo
);
    // Load on capture, otherwise shift toward bit 0 while shifting.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (capture) sr_q <= cap_word;
        else if (shift)   sr_q <= {tdi, sr_q[W-1:1]};
    end

    // Present bit 0 half a cycle later so the host samples a settled value.
    always_ff @(negedge clk) begin
        if (!rst_n) tdo <= 1'b0;
        else        tdo <= sr_q[0];
    end
endmodule

// File: rtl/dbg_reg_file.sv
// Host-writable debug control and optional vector catch registers.
// Assumes wr_en is a single-cycle write pulse from the update strobe.
module dbg_reg_file
    import dbg_chain_pkg::*;
#(
    parameter bit HAS_VEC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [VEC_W-1:0]  vec_q
);
    // Debug control: low bits of the write data, rest dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_q <= '0;
        else if (wr_en && wr_addr == A_CTRL)  ctrl_q <= wr_data[CTRL_W-1:0];
    end

    generate
        if (HAS_VEC) begin : g_vec
            // Vector catch register, present only when configured.
            always_ff @(posedge clk) begin
                if (!rst_n)                          vec_q <= '0;
                else if (wr_en && wr_addr == A_VEC)  vec_q <= wr_data;
            end
        end else begin : g_no_vec
            assign vec_q = '0;
        end
    endgenerate
endmodule

// File: rtl/dbg_mailbox.sv
// Two one-word slots between host and core, each guarded by a full flag.
// Assumes host_wr and host_rd come from the update and capture strobes.
module dbg_mailbox
    import dbg_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_word,
    input  logic              core_tx_valid,
    input  logic [DATA_W-1:0] core_tx_data,
    output logic              core_tx_ready,
    input  logic              core_rx_ack,
    output logic              core_rx_valid,
    output logic [DATA_W-1:0] core_rx_data,
    output logic              r_flag,
    output logic              w_flag
);
    // Host-to-core slot: fill when empty, empty on core acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_flag       <= 1'b0;
            core_rx_data <= '0;
        end else if (!r_flag && host_wr) begin
            r_flag       <= 1'b1;
            core_rx_data <= host_wdata;
        end else if (r_flag && core_rx_ack) begin
            r_flag       <= 1'b0;
        end
    end

    // Core-to-host slot: fill from core when empty, drain on host capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_flag    <= 1'b0;
            host_word <= '0;
        end else if (!w_flag && core_tx_valid) begin
            w_flag    <= 1'b1;
            host_word <= core_tx_data;
        end else if (w_flag && host_rd) begin
            w_flag    <= 1'b0;
        end
    end

    assign core_tx_ready = !w_flag;
    assign core_rx_valid = r_flag;
endmodule

// File: rtl/dbg_scan_chain.sv
// Top of the debug scan data register: decodes scan words, keeps the read
// address, muxes register contents into the capture word.
// Assumes strobes come from an external TAP, one at a time.
module dbg_scan_chain
    import dbg_chain_pkg::*;
#(
    parameter logic [VER_W-1:0] VERSION = 4'd6,
    parameter bit               HAS_VEC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic [STAT_W-1:0] dbg_status,
    output logic [CTRL_W-1:0] dbg_ctrl,
    output logic              monitor_en,
    output logic [VEC_W-1:0]  vec_catch,
    input  logic              core_tx_valid,
    input  logic [DATA_W-1:0] core_tx_data,
    output logic              core_tx_ready,
    output logic              core_rx_valid,
    output logic [DATA_W-1:0] core_rx_data,
    input  logic              core_rx_ack
);
    logic [SCAN_W-1:0] scan_q;
    logic [SCAN_W-1:0] cap_word;
    scan_word_t        sw;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] host_word;
    logic              r_flag, w_flag;
    logic              wr_upd, rd_upd, mb_wr, mb_rd;

    assign sw     = scan_word_t'(scan_q);
    assign wr_upd = update_dr && sw.wr;
    assign rd_upd = update_dr && !sw.wr;
    assign mb_wr  = wr_upd && sw.addr == A_MBDAT;
    assign mb_rd  = capture_dr && rd_addr == A_MBDAT;

    dbg_scan_shift #(.W(SCAN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .capture(capture_dr), .shift(shift_dr),
        .tdi(tdi), .cap_word(cap_word), .sr_q(scan_q), .tdo(tdo)
    );

    dbg_reg_file #(.HAS_VEC(HAS_VEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_upd), .wr_addr(sw.addr),
        .wr_data(sw.data[VEC_W-1:0]), .ctrl_q(dbg_ctrl), .vec_q(vec_catch)
    );

    dbg_mailbox u_mbox (
        .clk(clk), .rst_n(rst_n), .host_wr(mb_wr), .host_wdata(sw.data),
        .host_rd(mb_rd), .host_word(host_word),
        .core_tx_valid(core_tx_valid), .core_tx_data(core_tx_data),
        .core_tx_ready(core_tx_ready), .core_rx_ack(core_rx_ack),
        .core_rx_valid(core_rx_valid), .core_rx_data(core_rx_data),
        .r_flag(r_flag), .w_flag(w_flag)
    );

    // Read address follows read scans only; write scans keep it.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_addr <= '0;
        else if (rd_upd) rd_addr <= sw.addr;
    end

    // Select the contents of the latched read address.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  rd_data[CTRL_W-1:0] = dbg_ctrl;
            A_STAT:  rd_data[STAT_W-1:0] = dbg_status;
            A_VEC:   rd_data[VEC_W-1:0]  = vec_catch;
            A_MBSTS: begin
                rd_data[DATA_W-1 -: VER_W] = VERSION;
                rd_data[RFLAG_BIT]         = r_flag;
                rd_data[WFLAG_BIT]         = w_flag;
            end
            A_MBDAT: rd_data = host_word;
            default: rd_data = '0;
        endcase
    end

    assign cap_word   = {{(SCAN_W-DATA_W){1'b0}}, rd_data};
    assign monitor_en = dbg_ctrl[MON_BIT];
endmodule

// File: rtl/dbg_scan_chain_chk.sv
// Property checker for dbg_scan_chain, attached by bind below.
module dbg_scan_chain_chk
    import dbg_chain_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              capture_dr,
    input logic              update_dr,
    input logic [SCAN_W-1:0] scan_q,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CTRL_W-1:0] dbg_ctrl,
    input logic [VEC_W-1:0]  vec_catch,
    input logic              core_tx_valid,
    input logic              core_tx_ready,
    input logic              core_rx_valid,
    input logic [DATA_W-1:0] core_rx_data,
    input logic              core_rx_ack
);
    a_r4_reset_state: assert property (@(posedge clk)
        !rst_n |=> (dbg_ctrl == '0 && vec_catch == '0 && !core_rx_valid && core_tx_ready));

    a_r2_ctrl_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dbg_ctrl) |-> $past(update_dr && scan_q[SCAN_W-1] && scan_q[SCAN_W-2 -: ADDR_W] == A_CTRL));

    a_r6_rx_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rx_valid) |-> $past(update_dr && scan_q[SCAN_W-1] && scan_q[SCAN_W-2 -: ADDR_W] == A_MBDAT));

    a_r6_rx_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        core_rx_valid && !core_rx_ack |=> core_rx_valid && $stable(core_rx_data));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        core_rx_valid && core_rx_ack |=> !core_rx_valid);

    a_r8_tx_accept: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_valid && core_tx_ready |=> !core_tx_ready);

    a_r9_read_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr && rd_addr == A_MBDAT && !core_tx_ready |=> core_tx_ready);
endmodule

bind dbg_scan_chain dbg_scan_chain_chk i_chk (
    .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .update_dr(update_dr),
    .scan_q(scan_q), .rd_addr(rd_addr), .dbg_ctrl(dbg_ctrl), .vec_catch(vec_catch),
    .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready),
    .core_rx_valid(core_rx_valid), .core_rx_data(core_rx_data),
    .core_rx_ack(core_rx_ack)
);

// File: tb/test_dbg_scan_chain.sv
module test_dbg_scan_chain;
    localparam logic [3:0] VER = 4'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic        tdo;
    logic [4:0]  dbg_status = '0;
    logic [5:0]  dbg_ctrl;
    logic        monitor_en;
    logic [7:0]  vec_catch;
    logic        core_tx_valid = 0;
    logic [31:0] core_tx_data = '0;
    logic        core_tx_ready;
    logic        core_rx_valid;
    logic [31:0] core_rx_data;
    logic        core_rx_ack = 0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    logic [5:0]  m_ctrl = '0;
    logic [7:0]  m_vec = '0;
    bit          m_r = 0, m_w = 0;
    logic [31:0] m_rx = '0, m_tx = '0;

    always #5 clk = ~clk;

    dbg_scan_chain i_dbg_scan_chain (
        .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .dbg_status(dbg_status),
        .dbg_ctrl(dbg_ctrl), .monitor_en(monitor_en), .vec_catch(vec_catch),
        .core_tx_valid(core_tx_valid), .core_tx_data(core_tx_data),
        .core_tx_ready(core_tx_ready), .core_rx_valid(core_rx_valid),
        .core_rx_data(core_rx_data), .core_rx_ack(core_rx_ack)
    );

    function automatic logic [31:0] exp_sts(bit r, bit w);
        return {VER, 26'd0, w, r};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    // One full capture/shift/update pass; q is the captured 38-bit word.
    task automatic scan(input bit wr, input logic [4:0] a, input logic [31:0] d,
                        output logic [37:0] q);
        logic [37:0] v;
        v = {wr, a, d};
        capture_dr = 1; step(); capture_dr = 0;
        shift_dr = 1;
        for (int i = 0; i < 38; i++) begin
            tdi = v[i];
            q[i] = tdo;
            step();
        end
        shift_dr = 0; update_dr = 1; step(); update_dr = 0;
    endtask

    task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
        logic [37:0] q;
        scan(1'b1, a, d, q);
        if (a == 5'd0) m_ctrl = d[5:0];
        if (a == 5'd2) m_vec = d[7:0];
        if (a == 5'd5 && !m_r) begin m_r = 1; m_rx = d; end
    endtask

    task automatic hread(input logic [4:0] a, output logic [37:0] q);
        logic [37:0] dummy;
        scan(1'b0, a, 32'd0, dummy);
        scan(1'b0, 5'd4, 32'd0, q);
        if (a == 5'd5) m_w = 0;
    endtask

    task automatic core_send(input logic [31:0] d);
        core_tx_valid = 1; core_tx_data = d; step(); core_tx_valid = 0;
        if (!m_w) begin m_w = 1; m_tx = d; end
    endtask

    task automatic core_take();
        core_rx_ack = 1; step(); core_rx_ack = 0;
        m_r = 0;
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'd0: return {26'd0, m_ctrl};
            5'd1: return {27'd0, dbg_status};
            5'd2: return {24'd0, m_vec};
            5'd4: return exp_sts(m_r, m_w);
            5'd5: return m_tx;
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [37:0] q;
        logic [37:0] q2;
        void'($urandom(32'h5eed_1234));
        repeat (3) step();
        rst_n = 1; step();

        // R4 / R1: reset values
        chk("R1 tdo reset", {31'd0, tdo}, 32'd0);
        chk("R4 ctrl", {26'd0, dbg_ctrl}, 32'd0);
        chk("R4 vec", {24'd0, vec_catch}, 32'd0);
        chk("R4 flags", {30'd0, core_rx_valid, core_tx_ready}, 32'd1);
        hread(5'd4, q);
        chk("R5 status at reset", q[31:0], exp_sts(0, 0));
        chk("R3 upper capture bits zero", {26'd0, q[37:32]}, 32'd0);

        // R2: truncation and monitor enable
        hwrite(5'd0, 32'hFFFF_FFFF);
        chk("R2 ctrl truncated", {26'd0, dbg_ctrl}, 32'h3F);
        chk("R2 monitor_en set", {31'd0, monitor_en}, 32'd1);
        hwrite(5'd0, 32'h0000_000F);
        chk("R2 monitor_en clear", {31'd0, monitor_en}, 32'd0);
        hread(5'd0, q);
        chk("R2 ctrl readback", q[31:0], 32'h0F);
        hwrite(5'd2, 32'h0000_01A5);
        chk("R2 vec truncated", {24'd0, vec_catch}, 32'hA5);

        // R11: live status
        dbg_status = 5'h13;
        hread(5'd1, q);
        chk("R11 status read", q[31:0], 32'h13);

        // R10: read-only / unimplemented
        hwrite(5'd1, 32'hFFFF_FFFF);
        hwrite(5'd4, 32'hFFFF_FFFF);
        hwrite(5'd3, 32'hFFFF_FFFF);
        hwrite(5'd31, 32'hFFFF_FFFF);
        chk("R10 no rx flag from status write", {31'd0, core_rx_valid}, 32'd0);
        hread(5'd4, q);
        chk("R10 status unchanged", q[31:0], exp_sts(0, 0));
        hread(5'd3, q);
        chk("R10 addr3 reads zero", q[31:0], 32'd0);
        hread(5'd31, q);
        chk("R10 addr31 reads zero", q[31:0], 32'd0);
        hread(5'd0, q);
        chk("R10 ctrl untouched", q[31:0], 32'h0F);

        // R3: write scan does not move the read address
        scan(1'b0, 5'd2, 32'd0, q);
        scan(1'b1, 5'd0, 32'h2A, q);
        m_ctrl = 6'h2A;
        chk("R3 one-scan delay", q[31:0], 32'hA5);
        scan(1'b0, 5'd4, 32'd0, q);
        chk("R3 addr kept over write", q[31:0], 32'hA5);

        // R6 / R7: host to core
        hwrite(5'd5, 32'hDEAD_BEEF);
        chk("R6 rx valid", {31'd0, core_rx_valid}, 32'd1);
        chk("R6 rx data", core_rx_data, 32'hDEAD_BEEF);
        hwrite(5'd5, 32'h0000_1234);
        chk("R6 full write dropped", core_rx_data, 32'hDEAD_BEEF);
        hread(5'd4, q);
        chk("R5 R flag", q[31:0], exp_sts(1, 0));
        core_take();
        chk("R7 ack clears", {31'd0, core_rx_valid}, 32'd0);

        // R8 / R9: core to host
        core_send(32'hCAFE_F00D);
        chk("R8 not ready when full", {31'd0, core_tx_ready}, 32'd0);
        core_send(32'h1111_1111);
        hread(5'd4, q);
        chk("R5 W flag", q[31:0], exp_sts(0, 1));
        hread(5'd5, q);
        chk("R9 read word", q[31:0], 32'hCAFE_F00D);
        chk("R9 consumed", {31'd0, core_tx_ready}, 32'd1);

        // R9: repeated capture at address 5 consumes twice
        core_send(32'hAAAA_0001);
        scan(1'b0, 5'd5, 32'd0, q);
        scan(1'b0, 5'd5, 32'd0, q);
        chk("R9 first capture", q[31:0], 32'hAAAA_0001);
        m_w = 0;
        core_send(32'hBBBB_0002);
        scan(1'b0, 5'd4, 32'd0, q2);
        m_w = 0;
        chk("R9 second capture consumes", q2[31:0], 32'hBBBB_0002);
        chk("R9 ready after double", {31'd0, core_tx_ready}, 32'd1);

        // Random mix against the model
        for (int k = 0; k < 300; k++) begin
            int op;
            logic [4:0]  a;
            logic [31:0] d;
            op = $urandom_range(0, 4);
            d  = $urandom;
            a  = 5'($urandom_range(0, 7));
            case (op)
                0: hwrite(a, d);
                1: begin
                    dbg_status = d[4:0];
                    hread(a, q);
                    chk("R3 random read", q[31:0], exp_read(a));
                    if (a == 5'd5) m_w = 0;
                end
                2: begin
                    chk("R8 ready model", {31'd0, core_tx_ready}, {31'd0, !m_w});
                    core_send(d);
                end
                3: begin
                    chk("R6 rx model", {31'd0, core_rx_valid}, {31'd0, m_r});
                    if (m_r) chk("R6 rx word", core_rx_data, m_rx);
                    core_take();
                end
                default: begin
                    chk("R2 ctrl model", {26'd0, dbg_ctrl}, {26'd0, m_ctrl});
                    chk("R2 vec model", {24'd0, vec_catch}, {24'd0, m_vec});
                end
            endcase
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule